// File: doc/BRIEF.md
# Eight-Channel Pulse-Width Generator with Start-Level Control

This block produces eight pulse-width modulated outputs from a small register port. Every channel owns an 8-bit period, an 8-bit duty value, a start-level bit, a strobe-select bit and an enable bit. Its counter advances only on a tick of one of four clock-enable strobes supplied from outside: the base and scaled strobes of group A feed channels 0, 1, 4 and 5, and the base and scaled strobes of group B feed channels 2, 3, 6 and 7. A neighbouring pair of channels (0/1, 2/3, 4/5, 6/7) can be joined into one 16-bit channel whose waveform appears on the odd pin.

Each channel core runs a three-state machine. `CH_IDLE` (disabled: pin low, counter 0) moves to `CH_ARMED` once the stored enable is seen. `CH_ARMED` waits for the next tick of the selected strobe. That tick moves it to `CH_RUN` with the counter at 0, and `CH_ARMED` returns to `CH_IDLE` if the enable is dropped first. In `CH_RUN` each tick advances the counter, and the counter wraps at period minus one. Clearing the enable sends `CH_RUN` back to `CH_IDLE`. Start-level and strobe-select changes act on the next system clock, mid-period, so a shortened or lengthened pulse during such a change is expected.

Top module: `pwm_top`

## Requirements
- R1: After reset every register reads 0 and all eight pins are low.
- R2: Register addresses: 0 enable (bit n = channel n), 1 start level, 2 strobe select, 3 pair join (bit p = pair p, bits 7:4 read 0), 8+n period of channel n, 16+n duty of channel n. Reads return the stored value, and unused addresses read 0.
- R3: A running channel with start level 0 is low while counter < duty and high from counter = duty on. With start level 1 the levels are inverted.
- R4: A running counter advances by one on each tick of the selected strobe and wraps to 0 after period-1. With period 0 or 1 it stays at 0. The pin returns to its start level at the wrap.
- R5: Strobe mask bit order {tick_sb, tick_b, tick_sa, tick_a}. Channels 0,1,4,5 use tick_a (select 0) or tick_sa (select 1). Channels 2,3,6,7 use tick_b (select 0) or tick_sb (select 1). The other three strobes do not move the channel.
- R6: A newly set enable does not drive the pin in the clock of the write nor before the next tick of the selected strobe. That tick starts the period at counter 0.
- R7: A disabled channel drives its pin low and restarts from counter 0 when enabled again.
- R8: Duty 0, or duty at or above the period, keeps the pin at its start level for the whole period.
- R9: With a pair joined, the counter is 16 bits wide. The even channel's period/duty are the high byte and the odd channel's the low byte. The odd channel's enable, start level and select govern the pair, and the result drives the odd pin. The even pin is low, and the even enable and start level have no effect.
- R10: Start-level and strobe-select writes take effect in the next clock, without waiting for a period end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_a | input | 1 | Group A base clock-enable strobe |
| tick_sa | input | 1 | Group A scaled clock-enable strobe |
| tick_b | input | 1 | Group B base clock-enable strobe |
| tick_sb | input | 1 | Group B scaled clock-enable strobe |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Register address |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr` |
| pwm_out | output | 8 | PWM pins, bit n = channel n |

## Verification
The bench sweeps every channel over periods 0 to 4, over every duty from 0 to one past the period, and over both start levels. This covers the degenerate periods and the boundaries where duty is 0 or reaches the period. A design with an off-by-one wrap or duty compare would show a pin that flips one tick early or late, or a stray pulse when duty is 0. The wrong-group strobes are pulsed mid-period, which exposes a channel bound to the wrong clock group, because its counter would advance and its pin would change level. An enable that is written together with a tick exposes a design that starts early. A joined pair is run over a 259-count period to catch a lost high byte or a live even pin. A start-level flip and a strobe-select change mid-period catch a design that defers these changes to the period end.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    typedef enum logic [1:0] {
        CH_IDLE  = 2'd0,
        CH_ARMED = 2'd1,
        CH_RUN   = 2'd2
    } ch_state_e;

    localparam int ADR_EN   = 0;
    localparam int ADR_POL  = 1;
    localparam int ADR_SEL  = 2;
    localparam int ADR_CAT  = 3;
    localparam int ADR_PER  = 8;
    localparam int ADR_DUTY = 16;

endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
    import pwm_pkg::*;
#(
    parameter int NCH = 8,
    parameter int DW  = 8,
    parameter int AW  = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [AW-1:0]            addr,
    input  logic [DW-1:0]            wr_data,
    output logic [DW-1:0]            rd_data,
    output logic [NCH-1:0]           en_o,
    output logic [NCH-1:0]           pol_o,
    output logic [NCH-1:0]           sel_o,
    output logic [NCH/2-1:0]         cat_o,
    output logic [NCH-1:0][DW-1:0]   per_o,
    output logic [NCH-1:0][DW-1:0]   duty_o
);

    localparam int NPAIR = NCH / 2;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_o   <= '0;
            pol_o  <= '0;
            sel_o  <= '0;
            cat_o  <= '0;
            per_o  <= '0;
            duty_o <= '0;
        end else if (wr_en) begin
            if (addr == AW'(ADR_EN))  en_o  <= wr_data[NCH-1:0];
            if (addr == AW'(ADR_POL)) pol_o <= wr_data[NCH-1:0];
            if (addr == AW'(ADR_SEL)) sel_o <= wr_data[NCH-1:0];
            if (addr == AW'(ADR_CAT)) cat_o <= wr_data[NPAIR-1:0];
            for (int n = 0; n < NCH; n++) begin
                if (addr == AW'(ADR_PER + n))  per_o[n]  <= wr_data;
                if (addr == AW'(ADR_DUTY + n)) duty_o[n] <= wr_data;
            end
        end
    end

    always_comb begin
        rd_data = '0;
        if (addr == AW'(ADR_EN))  rd_data = DW'(en_o);
        if (addr == AW'(ADR_POL)) rd_data = DW'(pol_o);
        if (addr == AW'(ADR_SEL)) rd_data = DW'(sel_o);
        if (addr == AW'(ADR_CAT)) rd_data = DW'(cat_o);
        for (int n = 0; n < NCH; n++) begin
            if (addr == AW'(ADR_PER + n))  rd_data = per_o[n];
            if (addr == AW'(ADR_DUTY + n)) rd_data = duty_o[n];
        end
    end

endmodule

// File: rtl/pwm_core.sv
module pwm_core
    import pwm_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          pol,
    input  logic          tick,
    input  logic [CW-1:0] period,
    input  logic [CW-1:0] duty,
    output logic          out
);

    ch_state_e     st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [CW:0]   cnt_inc;
    logic          wrap;
    logic          past_duty;

    assign cnt_inc   = {1'b0, cnt_q} + 1'b1;
    assign wrap      = cnt_inc >= {1'b0, period};
    assign past_duty = (duty != '0) && (cnt_q >= duty);

    // next-state and counter
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            CH_IDLE: begin
                cnt_d = '0;
                if (en) st_d = CH_ARMED;
            end
            CH_ARMED: begin
                cnt_d = '0;
                if (!en)       st_d = CH_IDLE;
                else if (tick) st_d = CH_RUN;
            end
            CH_RUN: begin
                if (!en) begin
                    st_d  = CH_IDLE;
                    cnt_d = '0;
                end else if (tick) begin
                    cnt_d = wrap ? '0 : cnt_inc[CW-1:0];
                end
            end
            default: begin
                st_d  = CH_IDLE;
                cnt_d = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= CH_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // output
    always_comb begin
        unique case (st_q)
            CH_RUN:  out = pol ^ past_duty;
            default: out = 1'b0;
        endcase
    end

endmodule

// File: rtl/pwm_pair.sv
module pwm_pair #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    en,
    input  logic [1:0]    pol,
    input  logic [1:0]    sel,
    input  logic          cat,
    input  logic          tick_base,
    input  logic          tick_scaled,
    input  logic [DW-1:0] per_e,
    input  logic [DW-1:0] per_o,
    input  logic [DW-1:0] duty_e,
    input  logic [DW-1:0] duty_o,
    output logic [1:0]    out
);

    localparam int WW = 2 * DW;

    logic          tick_e, tick_o;
    logic          out_e, out_o;
    logic [WW-1:0] per_w, duty_w;

    assign tick_e = sel[0] ? tick_scaled : tick_base;
    assign tick_o = sel[1] ? tick_scaled : tick_base;
    assign per_w  = cat ? {per_e, per_o}   : {{DW{1'b0}}, per_o};
    assign duty_w = cat ? {duty_e, duty_o} : {{DW{1'b0}}, duty_o};

    pwm_core #(.CW(DW)) u_even (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (en[0] & ~cat),
        .pol    (pol[0]),
        .tick   (tick_e),
        .period (per_e),
        .duty   (duty_e),
        .out    (out_e)
    );

    pwm_core #(.CW(WW)) u_odd (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (en[1]),
        .pol    (pol[1]),
        .tick   (tick_o),
        .period (per_w),
        .duty   (duty_w),
        .out    (out_o)
    );

    assign out = {out_o, out_e & ~cat};

endmodule

// File: rtl/pwm_top.sv
module pwm_top
    import pwm_pkg::*;
#(
    parameter int NCH = 8,
    parameter int DW  = 8,
    parameter int AW  = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick_a,
    input  logic           tick_sa,
    input  logic           tick_b,
    input  logic           tick_sb,
    input  logic           wr_en,
    input  logic [AW-1:0]  addr,
    input  logic [DW-1:0]  wr_data,
    output logic [DW-1:0]  rd_data,
    output logic [NCH-1:0] pwm_out
);

    localparam int NPAIR = NCH / 2;

    logic [NCH-1:0]         en_q, pol_q, sel_q;
    logic [NPAIR-1:0]       cat_q;
    logic [NCH-1:0][DW-1:0] per_q, duty_q;

    pwm_regs #(.NCH(NCH), .DW(DW), .AW(AW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .addr    (addr),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .en_o    (en_q),
        .pol_o   (pol_q),
        .sel_o   (sel_q),
        .cat_o   (cat_q),
        .per_o   (per_q),
        .duty_o  (duty_q)
    );

    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        // pairs 0,2 -> group A ; pairs 1,3 -> group B
        logic base_t, scaled_t;
        if ((p % 2) == 0) begin : g_grp_a
            assign base_t   = tick_a;
            assign scaled_t = tick_sa;
        end else begin : g_grp_b
            assign base_t   = tick_b;
            assign scaled_t = tick_sb;
        end

        pwm_pair #(.DW(DW)) u_pair (
            .clk         (clk),
            .rst_n       (rst_n),
            .en          (en_q[2*p +: 2]),
            .pol         (pol_q[2*p +: 2]),
            .sel         (sel_q[2*p +: 2]),
            .cat         (cat_q[p]),
            .tick_base   (base_t),
            .tick_scaled (scaled_t),
            .per_e       (per_q[2*p]),
            .per_o       (per_q[2*p+1]),
            .duty_e      (duty_q[2*p]),
            .duty_o      (duty_q[2*p+1]),
            .out         (pwm_out[2*p +: 2])
        );
    end

endmodule

// File: rtl/pwm_checker.sv
module pwm_checker #(
    parameter int NCH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [3:0]       ticks,
    input logic             wr_en,
    input logic [NCH-1:0]   en_q,
    input logic [NCH/2-1:0] cat_q,
    input logic [NCH-1:0]   pwm_out
);

    logic [NCH-1:0] cat_even;

    always_comb begin
        cat_even = '0;
        for (int p = 0; p < NCH / 2; p++) cat_even[2*p] = cat_q[p];
    end

    AST_DISABLED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ((~en_q & ~$past(en_q) & pwm_out) == '0)); // R7

    AST_JOINED_EVEN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ((cat_even & $past(cat_even) & pwm_out) == '0)); // R9

    AST_ENABLE_DEFERRED: assert property (@(posedge clk) disable iff (!rst_n)
        ((en_q & ~$past(en_q) & pwm_out) == '0)); // R6

    AST_QUIET_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(|ticks) && !$past(wr_en) && !$past(wr_en, 2)) |-> $stable(pwm_out)); // R4

endmodule

bind pwm_top pwm_checker #(.NCH(NCH)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ticks   ({tick_sb, tick_b, tick_sa, tick_a}),
    .wr_en   (wr_en),
    .en_q    (en_q),
    .cat_q   (cat_q),
    .pwm_out (pwm_out)
);

// File: tb/test_pwm_top.sv
module test_pwm_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       tick_a, tick_sa, tick_b, tick_sb;
    logic       wr_en;
    logic [4:0] addr;
    logic [7:0] wr_data;
    logic [7:0] rd_data;
    logic [7:0] pwm_out;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    pwm_top i_pwm_top (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_a  (tick_a),
        .tick_sa (tick_sa),
        .tick_b  (tick_b),
        .tick_sb (tick_sb),
        .wr_en   (wr_en),
        .addr    (addr),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .pwm_out (pwm_out)
    );

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wr(logic [4:0] a, logic [7:0] d);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse(logic [3:0] m);
        {tick_sb, tick_b, tick_sa, tick_a} = m;
        @(negedge clk);
        {tick_sb, tick_b, tick_sa, tick_a} = 4'b0;
    endtask

    task automatic rd_chk(string req, logic [4:0] a, logic [7:0] exp);
        addr = a;
        #1;
        chk(req, rd_data, exp);
    endtask

    function automatic logic [3:0] strobe(int ch, bit sel);
        return 4'b0001 << (((ch >> 1) & 1) * 2 + int'(sel));
    endfunction

    // one channel through two periods, model computed from R3/R4/R8
    task automatic run_chan(int ch, int per, int dty, bit pol, bit sel);
        int  plen;
        int  cnt;
        bit  lvl;
        logic [3:0] m;
        plen = (per < 1) ? 1 : per;
        m    = strobe(ch, sel);
        wr(5'(8 + ch), 8'(per));
        wr(5'(16 + ch), 8'(dty));
        wr(5'd1, 8'(pol) << ch);
        wr(5'd2, 8'(sel) << ch);
        wr(5'd0, 8'd1 << ch);
        @(negedge clk);
        chk("R6 armed before tick", pwm_out, 8'h00);
        for (int k = 0; k < 2 * plen; k++) begin
            pulse(m);
            cnt = k % plen;
            lvl = pol ^ ((dty != 0) && (cnt >= dty));
            chk("R3/R4/R8 waveform", pwm_out, 8'(lvl) << ch);
            if (k == 0) begin
                pulse(~m);
                chk("R5 foreign strobes ignored", pwm_out, 8'(lvl) << ch);
            end
        end
        wr(5'd0, 8'h00);
        @(negedge clk);
        chk("R7 disabled low", pwm_out, 8'h00);
    endtask

    initial begin
        rst_n = 1'b0;
        {tick_sb, tick_b, tick_sa, tick_a} = 4'b0;
        wr_en = 1'b0; addr = '0; wr_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values
        chk("R1 pins after reset", pwm_out, 8'h00);
        for (int a = 0; a < 24; a++) rd_chk("R1 register reset", 5'(a), 8'h00);

        // R2 map and readback
        wr(5'd3, 8'hFF);
        for (int n = 0; n < 8; n++) begin
            wr(5'(8 + n), 8'(8'h11 * n + 3));
            wr(5'(16 + n), 8'(8'h0F * n + 1));
        end
        wr(5'd1, 8'hA5);
        wr(5'd2, 8'h3C);
        rd_chk("R2 join reads four bits", 5'd3, 8'h0F);
        rd_chk("R2 start level", 5'd1, 8'hA5);
        rd_chk("R2 strobe select", 5'd2, 8'h3C);
        rd_chk("R2 unused address", 5'd5, 8'h00);
        for (int n = 0; n < 8; n++) begin
            rd_chk("R2 period", 5'(8 + n), 8'(8'h11 * n + 3));
            rd_chk("R2 duty", 5'(16 + n), 8'(8'h0F * n + 1));
        end
        wr(5'd3, 8'h00);
        wr(5'd1, 8'h00);
        wr(5'd2, 8'h00);

        // R3 R4 R5 R8 sweep
        for (int ch = 0; ch < 8; ch++)
            for (int per = 0; per <= 4; per++)
                for (int d = 0; d <= per + 1; d++)
                    for (int pl = 0; pl < 2; pl++)
                        run_chan(ch, per, d, bit'(pl), bit'((pl + d) & 1));

        // R6 enable written with a simultaneous tick
        wr(5'd8, 8'd4);
        wr(5'd16, 8'd2);
        wr(5'd1, 8'h01);
        {tick_sb, tick_b, tick_sa, tick_a} = 4'b1111;
        wr(5'd0, 8'h01);
        {tick_sb, tick_b, tick_sa, tick_a} = 4'b0;
        chk("R6 no drive in write clock", pwm_out, 8'h00);
        @(negedge clk);
        chk("R6 no drive before tick", pwm_out, 8'h00);
        pulse(4'b0001);
        chk("R6 first tick starts at count 0", pwm_out, 8'h01);

        // R7 disable then restart from 0
        wr(5'd1, 8'h00);
        pulse(4'b0001);
        pulse(4'b0001);
        chk("R7 count 2 high", pwm_out, 8'h01);
        wr(5'd0, 8'h00);
        @(negedge clk);
        chk("R7 disabled low", pwm_out, 8'h00);
        pulse(4'b0001);
        chk("R7 tick while disabled", pwm_out, 8'h00);
        wr(5'd0, 8'h01);
        @(negedge clk);
        pulse(4'b0001);
        chk("R7 restart count 0 low", pwm_out, 8'h00);
        pulse(4'b0001);
        chk("R7 restart count 1 low", pwm_out, 8'h00);
        pulse(4'b0001);
        chk("R7 restart count 2 high", pwm_out, 8'h01);
        wr(5'd0, 8'h00);
        @(negedge clk);

        // R10 immediate start level and select changes on channel 3
        wr(5'd11, 8'd4);
        wr(5'd19, 8'd2);
        wr(5'd1, 8'h00);
        wr(5'd2, 8'h08);
        wr(5'd0, 8'h08);
        @(negedge clk);
        pulse(4'b1000);
        chk("R10 running count 0 low", pwm_out, 8'h00);
        wr(5'd1, 8'h08);
        chk("R10 start level flips mid-period", pwm_out, 8'h08);
        wr(5'd2, 8'h00);
        pulse(4'b1000);
        chk("R10 old strobe no longer counts", pwm_out, 8'h08);
        pulse(4'b0100);
        chk("R10 new strobe count 1", pwm_out, 8'h08);
        pulse(4'b0100);
        chk("R10 new strobe count 2", pwm_out, 8'h00);
        wr(5'd0, 8'h00);
        @(negedge clk);

        // R9 joined pair 0/1: period 0x0103, duty 0x0101
        wr(5'd8, 8'h01);
        wr(5'd9, 8'h03);
        wr(5'd16, 8'h01);
        wr(5'd17, 8'h01);
        wr(5'd3, 8'h01);
        wr(5'd1, 8'h01);
        wr(5'd2, 8'h00);
        wr(5'd0, 8'h03);
        @(negedge clk);
        chk("R9 joined pair armed", pwm_out, 8'h00);
        for (int k = 0; k < 2 * 259; k++) begin
            pulse(4'b0001);
            chk("R9 joined waveform", pwm_out, ((k % 259) >= 257) ? 8'h02 : 8'h00);
        end
        wr(5'd0, 8'h00);
        wr(5'd3, 8'h00);
        @(negedge clk);

        $display("test done: total=%0d bad=%0d", total, bad);
        done = 1'b1;
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule